// File: doc/BRIEF.md
# Watch Mode Power Controller

This block is the mode sequencer of a small microcontroller core. It knows which of four operating modes the chip is in: full-speed active, reduced-speed active, low-speed subactive, or watch. When the CPU executes its sleep instruction with both the standby-select and watch-enable control bits set, the controller moves to watch mode. In watch mode the CPU clock enable drops, and every peripheral clock enable is turned off except those of the timekeeping timers, the event counter and (if its run bit asks for it) the display driver.

An interrupt can end watch mode only when the global interrupt mask is clear and that source's own enable bit is set. There are twelve such sources: three timers, one external interrupt line and eight wake-up pins. Two select bits pick the mode to return to. A return to either active mode first waits out an oscillator settling time. The wait is chosen by a 3-bit code and counted in ticks of a free-running slow clock enable. Once the target mode is reached, the block raises a one-cycle pulse that starts interrupt exception handling. Reset ends any mode and forces full-speed active.

Top module: `watch_mode_ctrl`

## Requirements
- R1: Once reset is released, the mode vector is full-speed active (value 1). `cpu_clk_en` is 1, every bit of `periph_clk_en` is 1 and `wake_exc` is 0. Mode vector bits: 0 full-speed active, 1 reduced-speed active, 2 subactive, 3 watch.
- R2: A cycle with `sleep_req`, `standby_sel` and `watch_en` all 1 moves the mode from any of the three running modes to watch (value 8) at the next clock edge.
- R3: A sleep request with `watch_en` or `standby_sel` at 0 leaves the mode unchanged. A wake request made outside watch mode leaves the mode unchanged and gives no exception pulse.
- R4: In watch mode and during the settling wait, `periph_clk_en` bits 0 to 3 stay 1. Bit 0 is the watch timer, bits 1 and 2 are the other timers and bit 3 is the event counter. Bit 4 (display) follows `lcd_run`, and bits 5 and up are 0.
- R5: A request on `wake_req[i]` ends watch mode only when `irq_mask` is 0 and `wake_en[i]` is 1. With any other combination the mode stays at watch.
- R6: On a qualified wake, the return mode depends on `lowspeed_sel` and `medspeed_sel`. `lowspeed_sel`=1 returns to subactive whatever `medspeed_sel` is. With `lowspeed_sel`=0, `medspeed_sel`=1 returns to reduced-speed active and `medspeed_sel`=0 returns to full-speed active.
- R7: A return to an active mode first waits a number of `slow_tick` pulses set by `settle_sel`. Codes 0 to 4 give 8192, 16384, 32768, 65536 and 131072 pulses; codes 5, 6 and 7 give 2, 8 and 16. The mode shows watch until the edge that takes the last pulse, and at that edge it becomes the target. Cycles without a pulse do not count.
- R8: A return to subactive applies no wait: the mode changes at the edge that samples the qualified wake.
- R9: `wake_exc` is high for exactly one cycle, the cycle after the mode changes to the return target.
- R10: `cpu_clk_en` is 0 in watch mode and for the whole settling wait, and 1 in every other mode.
- R11: Asserting `rst_n` during watch mode or the settling wait returns the mode to full-speed active at once, with all clock enables high.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Free-running slow clock enable used to count the settling wait |
| sleep_req | input | 1 | Sleep instruction executed |
| standby_sel | input | 1 | Standby-select control bit |
| watch_en | input | 1 | Watch-enable control bit |
| lowspeed_sel | input | 1 | Return to subactive on wake |
| medspeed_sel | input | 1 | Return to reduced-speed active when `lowspeed_sel` is 0 |
| settle_sel | input | 3 | Settling wait length code |
| lcd_run | input | 1 | Keep the display clock running in watch mode |
| irq_mask | input | 1 | Global interrupt mask |
| wake_req | input | N_SRC | Wake interrupt requests |
| wake_en | input | N_SRC | Per-source wake enables |
| mode_onehot | output | 4 | Current mode, one-hot |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | N_PERIPH | Peripheral clock enables |
| wake_exc | output | 1 | One-cycle interrupt exception request after wake |

## Verification
The bench sweeps all twelve wake sources against every combination of mask and enable. A qualifier that inverted the mask, or that let an enabled source other than the requesting one count, would leave watch when it should not, or stay when it should leave. It runs six settling codes to the exact edge, plus a sparse-pulse case. An off-by-one or wrongly ordered length table, or a counter that ran on every cycle, would change the mode one edge early or late. It checks the pulse timing against both a subactive return and an active return, and checks the display enable and an asynchronous reset in the middle of the settling wait.

// File: rtl/wmc_pkg.sv
package wmc_pkg;

  typedef enum logic [2:0] {
    ST_HS     = 3'd0,
    ST_MS     = 3'd1,
    ST_SUB    = 3'd2,
    ST_WATCH  = 3'd3,
    ST_SETTLE = 3'd4
  } wmc_state_e;

  localparam int MODE_W   = 4;
  localparam int M_HS     = 0;
  localparam int M_MS     = 1;
  localparam int M_SUB    = 2;
  localparam int M_WATCH  = 3;
  localparam int SETTLE_W = 18;

  function automatic logic [SETTLE_W-1:0] settle_len(input logic [2:0] code);
    logic [SETTLE_W-1:0] len;
    case (code)
      3'd5:    len = SETTLE_W'(2);
      3'd6:    len = SETTLE_W'(8);
      3'd7:    len = SETTLE_W'(16);
      default: len = SETTLE_W'(1) << (13 + int'(code));
    endcase
    return len;
  endfunction

endpackage

// File: rtl/wake_qualifier.sv
module wake_qualifier #(
  parameter int N_SRC = 12
) (
  input  logic [N_SRC-1:0] wake_req,
  input  logic [N_SRC-1:0] wake_en,
  input  logic             irq_mask,
  output logic             wake_hit
);

  logic [N_SRC-1:0] armed;

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_src
      assign armed[gi] = wake_req[gi] & wake_en[gi];
    end
  endgenerate

  assign wake_hit = (|armed) & ~irq_mask;

endmodule

// File: rtl/settle_timer.sv
module settle_timer
  import wmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] code,
  input  logic       run,
  input  logic       tick,
  output logic       done
);

  logic [SETTLE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = settle_len(code);
    else if (run && tick && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run & tick & (cnt_q == SETTLE_W'(1));

  // R7
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q != '0);

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/periph_gate.sv
module periph_gate #(
  parameter int N_PERIPH = 8,
  parameter int N_KEEP   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gate,
  input  logic                lcd_run,
  output logic [N_PERIPH-1:0] en
);

  localparam int LCD_IDX = N_KEEP;

  genvar gi;
  generate
    for (gi = 0; gi < N_PERIPH; gi++) begin : g_en
      if (gi < N_KEEP) begin : g_keep
        assign en[gi] = 1'b1;
      end else if (gi == LCD_IDX) begin : g_lcd
        assign en[gi] = ~gate | lcd_run;
      end else begin : g_off
        assign en[gi] = ~gate;
      end
    end
  endgenerate

  // R4
  watch_timer_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> en[0]);

  // R4
  top_bit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> !en[N_PERIPH-1]);

endmodule

// File: rtl/watch_mode_ctrl.sv
module watch_mode_ctrl
  import wmc_pkg::*;
#(
  parameter int N_SRC    = 12,
  parameter int N_PERIPH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slow_tick,
  input  logic                sleep_req,
  input  logic                standby_sel,
  input  logic                watch_en,
  input  logic                lowspeed_sel,
  input  logic                medspeed_sel,
  input  logic [2:0]          settle_sel,
  input  logic                lcd_run,
  input  logic                irq_mask,
  input  logic [N_SRC-1:0]    wake_req,
  input  logic [N_SRC-1:0]    wake_en,
  output logic [MODE_W-1:0]   mode_onehot,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                wake_exc
);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  wmc_state_e state_q, state_d, target_q, target_d;
  logic       resume_q, resume_d, exc_q;
  logic       wake_hit, settle_load, settle_done, gated;

  wake_qualifier #(.N_SRC(N_SRC)) u_wq (
    .wake_req (wake_req),
    .wake_en  (wake_en),
    .irq_mask (irq_mask),
    .wake_hit (wake_hit)
  );

  settle_timer u_st (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (settle_load),
    .code  (settle_sel),
    .run   (state_q == ST_SETTLE),
    .tick  (slow_tick),
    .done  (settle_done)
  );

  always_comb begin
    state_d     = state_q;
    target_d    = target_q;
    settle_load = 1'b0;
    resume_d    = 1'b0;
    case (state_q)
      ST_HS, ST_MS, ST_SUB: begin
        if (sleep_req && standby_sel && watch_en) state_d = ST_WATCH;
      end
      ST_WATCH: begin
        if (wake_hit) begin
          if (lowspeed_sel) begin
            state_d  = ST_SUB;
            resume_d = 1'b1;
          end else begin
            state_d     = ST_SETTLE;
            target_d    = medspeed_sel ? ST_MS : ST_HS;
            settle_load = 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        if (settle_done) begin
          state_d  = target_q;
          resume_d = 1'b1;
        end
      end
      default: state_d = ST_HS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HS;
      target_q <= ST_HS;
      resume_q <= 1'b0;
      exc_q    <= 1'b0;
    end else if (rst_i_n) begin
      state_q  <= state_d;
      target_q <= target_d;
      resume_q <= resume_d;
      exc_q    <= resume_q;
    end
  end

  assign gated = (state_q == ST_WATCH) || (state_q == ST_SETTLE);

  always_comb begin
    mode_onehot = '0;
    case (state_q)
      ST_MS:   mode_onehot[M_MS]    = 1'b1;
      ST_SUB:  mode_onehot[M_SUB]   = 1'b1;
      ST_HS:   mode_onehot[M_HS]    = 1'b1;
      default: mode_onehot[M_WATCH] = 1'b1;
    endcase
  end

  assign cpu_clk_en = ~gated;
  assign wake_exc   = exc_q;

  periph_gate #(.N_PERIPH(N_PERIPH), .N_KEEP(4)) u_pg (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .gate    (gated),
    .lcd_run (lcd_run),
    .en      (periph_clk_en)
  );

  // R1
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones(mode_onehot) == 1);

  // R9
  exc_single_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    wake_exc |=> !wake_exc);

  // R9
  exc_after_change_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    wake_exc |-> !$past(mode_onehot[M_WATCH]) && $past(mode_onehot[M_WATCH], 2));

  // R3
  sleep_ignored_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_clk_en && !watch_en) |=> !mode_onehot[M_WATCH]);

  // R10
  cpu_gated_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mode_onehot[M_WATCH] |-> !cpu_clk_en);

  // R8
  sub_direct_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode_onehot[M_WATCH] && wake_hit && lowspeed_sel) |=> mode_onehot[M_SUB]);

endmodule

// File: tb/watch_mode_ctrl_tb.sv
module watch_mode_ctrl_tb;

  localparam int NS = 12;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n, slow_tick, sleep_req, standby_sel, watch_en;
  logic lowspeed_sel, medspeed_sel, lcd_run, irq_mask;
  logic [2:0]    settle_sel;
  logic [NS-1:0] wake_req, wake_en;
  logic [3:0]    mode_onehot;
  logic          cpu_clk_en, wake_exc;
  logic [NP-1:0] periph_clk_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  watch_mode_ctrl #(.N_SRC(NS), .N_PERIPH(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sleep_req(sleep_req),
    .standby_sel(standby_sel), .watch_en(watch_en), .lowspeed_sel(lowspeed_sel),
    .medspeed_sel(medspeed_sel), .settle_sel(settle_sel), .lcd_run(lcd_run),
    .irq_mask(irq_mask), .wake_req(wake_req), .wake_en(wake_en),
    .mode_onehot(mode_onehot), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .wake_exc(wake_exc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  function automatic int len_of(input int code);
    if (code == 5) return 2;
    if (code == 6) return 8;
    if (code == 7) return 16;
    return 8192 << code;
  endfunction

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_watch();
    sleep_req = 1'b1; standby_sel = 1'b1; watch_en = 1'b1;
    nclk(1);
    sleep_req = 1'b0;
    chk_eq("R2 enter watch", int'(mode_onehot), 8);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    nclk(2);
    rst_n = 1'b1;
    nclk(3);
  endtask

  initial begin
    rst_n = 1'b0; slow_tick = 1'b1; sleep_req = 1'b0; standby_sel = 1'b0;
    watch_en = 1'b0; lowspeed_sel = 1'b0; medspeed_sel = 1'b0; lcd_run = 1'b0;
    irq_mask = 1'b0; settle_sel = 3'd5; wake_req = '0; wake_en = '0;
    do_reset();

    // R1 reset state
    chk_eq("R1 mode", int'(mode_onehot), 1);
    chk_eq("R1 cpu_clk_en", int'(cpu_clk_en), 1);
    chk_eq("R1 periph", int'(periph_clk_en), 255);
    chk_eq("R1 wake_exc", int'(wake_exc), 0);

    // R3 sleep without both control bits
    for (int c = 0; c < 3; c++) begin
      standby_sel = c[0]; watch_en = c[1]; sleep_req = 1'b1;
      nclk(1);
      sleep_req = 1'b0;
      nclk(1);
      chk_eq("R3 sleep ignored", int'(mode_onehot), 1);
    end
    wake_en = '1; wake_req = 12'h001;
    nclk(1);
    wake_req = '0;
    nclk(1);
    chk_eq("R3 wake outside watch mode", int'(mode_onehot), 1);
    chk_eq("R3 wake outside watch exc", int'(wake_exc), 0);

    // R2 R4 R10 watch entry and gating
    enter_watch();
    chk_eq("R10 cpu gated", int'(cpu_clk_en), 0);
    chk_eq("R4 periph lcd off", int'(periph_clk_en), 15);
    lcd_run = 1'b1;
    nclk(1);
    chk_eq("R4 periph lcd on", int'(periph_clk_en), 31);
    lcd_run = 1'b0;

    // R5 R8 R9 wake qualification sweep, subactive return
    lowspeed_sel = 1'b1;
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < 4; c++) begin
        bit exp_wake;
        irq_mask = c[0];
        wake_en  = c[1] ? (NS'(1) << s) : ~(NS'(1) << s);
        wake_req = NS'(1) << s;
        medspeed_sel = c[1];
        exp_wake = !c[0] && c[1];
        nclk(1);
        wake_req = '0;
        if (exp_wake) begin
          chk_eq("R5 R8 wake to subactive", int'(mode_onehot), 4);
          chk_eq("R9 no exc in change cycle", int'(wake_exc), 0);
          nclk(1);
          chk_eq("R9 exc pulse", int'(wake_exc), 1);
          nclk(1);
          chk_eq("R9 exc single", int'(wake_exc), 0);
          enter_watch();
        end else begin
          chk_eq("R5 unqualified stays", int'(mode_onehot), 8);
          chk_eq("R5 unqualified no exc", int'(wake_exc), 0);
        end
      end
    end
    irq_mask = 1'b0; wake_en = '1;

    // R6 R7 R10 active returns with settling
    for (int i = 0; i < 6; i++) begin
      int code, n, tgt;
      code = (i < 3) ? i + 5 : i - 3;
      n    = len_of(code);
      medspeed_sel = i[0];
      tgt  = i[0] ? 2 : 1;
      lowspeed_sel = 1'b0;
      settle_sel = 3'(code);
      wake_req = 12'h080;
      nclk(1);
      wake_req = '0;
      settle_sel = 3'd7 - 3'(code);
      nclk(n - 1);
      chk_eq("R7 still watch at last tick", int'(mode_onehot), 8);
      chk_eq("R10 cpu gated in settle", int'(cpu_clk_en), 0);
      chk_eq("R4 periph gated in settle", int'(periph_clk_en), 15);
      nclk(1);
      chk_eq("R6 R7 active target", int'(mode_onehot), tgt);
      chk_eq("R10 cpu running", int'(cpu_clk_en), 1);
      chk_eq("R9 no exc yet", int'(wake_exc), 0);
      nclk(1);
      chk_eq("R9 exc after active return", int'(wake_exc), 1);
      nclk(1);
      chk_eq("R9 exc single active", int'(wake_exc), 0);
      enter_watch();
    end

    // R6 subactive regardless of medspeed_sel
    lowspeed_sel = 1'b1; medspeed_sel = 1'b1; wake_req = 12'h800;
    nclk(1);
    wake_req = '0;
    chk_eq("R6 lowspeed wins", int'(mode_onehot), 4);
    nclk(2);
    enter_watch();

    // R7 sparse ticks: only pulses count
    lowspeed_sel = 1'b0; medspeed_sel = 1'b0; settle_sel = 3'd6;
    slow_tick = 1'b0; wake_req = 12'h010;
    nclk(1);
    wake_req = '0;
    nclk(5);
    chk_eq("R7 no tick no count", int'(mode_onehot), 8);
    for (int k = 1; k <= 8; k++) begin
      slow_tick = 1'b1;
      nclk(1);
      slow_tick = 1'b0;
      chk_eq("R7 sparse tick count", int'(mode_onehot), (k == 8) ? 1 : 8);
      nclk(2);
    end
    slow_tick = 1'b1;

    // R11 reset during settling wait
    enter_watch();
    settle_sel = 3'd1; wake_req = 12'h002;
    nclk(1);
    wake_req = '0;
    nclk(100);
    #1 rst_n = 1'b0;
    #1;
    chk_eq("R11 reset mode", int'(mode_onehot), 1);
    chk_eq("R11 reset cpu", int'(cpu_clk_en), 1);
    chk_eq("R11 reset periph", int'(periph_clk_en), 255);
    nclk(1);
    rst_n = 1'b1;
    nclk(3);
    chk_eq("R11 after reset", int'(mode_onehot), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule